// File: doc/BRIEF.md
# Display Controller Host Register Interface with Light-Pen Capture

This block sits between a host processor and the raster timing and cursor logic of a character display controller. The host sees only two locations, picked by a select line. One location is a 5-bit index register that can only be written. The other is a window onto the register that the index points at. Each indexed register has its own access rule and its own field width. The stored settings leave the block as parallel fields that the horizontal, vertical, cursor and address generators use directly.

A bus transfer is committed when the enable strobe falls. The block samples chip select, the select line, the direction line and the write data on every character-clock edge while enable is high, and it acts on the last sampled values once enable is seen low. The data bus is split into an input, an output and a drive enable for the bidirectional pad.

The light-pen input is asynchronous to the character clock. It passes through a two-stage synchronizer and an edge detector. On each rising edge the current 14-bit refresh address is copied into a read-only register pair that the host can read back. Because of the synchronizer, the captured address lags the real beam position by a fixed number of character clocks.

Top module: `crtc_host_regs`

## Requirements
- R1: After reset every configuration output is 0, the index register is 0, the captured light-pen address is 0, and `bus_oe` is low.
- R2: A write with `bus_cs_n`=0, `bus_rs`=0 and `bus_rw`=0 loads data bits [4:0] into the index register. It is committed on the first character-clock edge at which `bus_en` is sampled low after being sampled high, using the control and data values sampled while `bus_en` was high.
- R3: A write with `bus_rs`=1 stores the data into the configuration register that the index selects, on the same commit edge as in R2. The index-to-output mapping is: 0 `h_total`, 1 `h_disp`, 2 `hs_pos`, 3 `hs_width`, 4 `v_total`, 5 `v_adjust`, 6 `v_disp`, 7 `vs_pos`, 8 `scan_mode`, 9 `row_max`, 10 `cur_start`, 11 `cur_end`, 12 and 13 the high and low bytes of `start_addr`, 14 and 15 the high and low bytes of `cursor_addr`. Without a commit, no output changes.
- R4: Each register keeps only its low bits and discards the rest. The widths are 8 bits for indices 0–3, 13 and 15; 7 bits for 4, 6, 7 and 10; 5 bits for 5, 9 and 11; 6 bits for 12 and 14; and 2 bits for 8.
- R5: Reads of indices 0–13, reads of indices 18–31, and reads with `bus_rs`=0 return 0x00.
- R6: Indices 14 and 15 read back the stored cursor address. Index 14 returns the six high address bits with bits [7:6] equal to 0, and index 15 returns the low byte.
- R7: Writes to index 16, 17 or 18–31 change no configuration output and do not change the captured light-pen value.
- R8: `bus_oe` is high exactly while `bus_cs_n`=0, `bus_rw`=1 and `bus_en`=1. `bus_dout` is meaningful only while `bus_oe` is high.
- R9: A transfer with `bus_cs_n`=1 writes neither the index nor any register.
- R10: If `pen_strobe` is first sampled high at clock edge k after being low, edge k+2 loads the `scan_addr` value present at that edge into the capture register. Index 16 reads bits [13:8] of that value (bits [7:6] read as 0), and index 17 reads bits [7:0].
- R11: Holding `pen_strobe` high causes only one capture. A new capture needs the strobe to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rs | input | 1 | 0 selects the index register, 1 selects the indexed register |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_en | input | 1 | Transfer strobe; a write commits when it falls |
| bus_din | input | 8 | Write data from the pad |
| bus_dout | output | 8 | Read data to the pad |
| bus_oe | output | 1 | Pad drive enable |
| pen_strobe | input | 1 | Asynchronous light-pen pulse |
| scan_addr | input | 14 | Current refresh address from the address generator |
| h_total | output | 8 | Index 0 |
| h_disp | output | 8 | Index 1 |
| hs_pos | output | 8 | Index 2 |
| hs_width | output | 8 | Index 3 |
| v_total | output | 7 | Index 4 |
| v_adjust | output | 5 | Index 5 |
| v_disp | output | 7 | Index 6 |
| vs_pos | output | 7 | Index 7 |
| scan_mode | output | 2 | Index 8 |
| row_max | output | 5 | Index 9 |
| cur_start | output | 7 | Index 10 |
| cur_end | output | 5 | Index 11 |
| start_addr | output | 14 | Indices 12 (high) and 13 (low) |
| cursor_addr | output | 14 | Indices 14 (high) and 15 (low) |

## Verification
The assertions assume that the bus controls are synchronous to the character clock and that `bus_en` stays high for at least one clock edge per transfer, so that the sampled values are the ones to commit. They also assume the light-pen pulse stays high for at least one clock. The stimulus changes every bus and strobe input only on falling clock edges and holds `bus_en` high for a full cycle. It holds each light-pen pulse for one or more cycles and keeps it low for several cycles between pulses, so the edge detector always sees a clean low-to-high step.

// File: rtl/crtc_regif_pkg.sv
package crtc_regif_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_CFG = 16;   // host-writable configuration registers
  localparam int IDX_CUR_HI = 14;
  localparam int IDX_CUR_LO = 15;
  localparam int IDX_PEN_HI = 16;
  localparam int IDX_PEN_LO = 17;

  // kept-bit mask per configuration index
  function automatic logic [DATA_W-1:0] field_mask(input int idx);
    case (idx)
      0, 1, 2, 3, 13, 15: field_mask = 8'hFF;
      4, 6, 7, 10:        field_mask = 8'h7F;
      5, 9, 11:           field_mask = 8'h1F;
      12, 14:             field_mask = 8'h3F;
      8:                  field_mask = 8'h03;
      default:            field_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/crtc_bus_port.sv
module crtc_bus_port
  import crtc_regif_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rs,
  input  logic              rw,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic              cfg_wr,
  output logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              rd_sel
);
  logic              en_q, lat_cs_n, lat_rs, lat_rw;
  logic [DATA_W-1:0] lat_d;
  logic              strobe_fall, commit, ptr_load;

  assign strobe_fall = en_q & ~en;
  assign commit      = strobe_fall & ~lat_cs_n & ~lat_rw;
  assign ptr_load    = commit & ~lat_rs;
  assign cfg_wr      = commit & lat_rs;
  assign wr_data     = lat_d;
  assign rd_sel      = ~cs_n & rw & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      lat_cs_n <= 1'b1;
      lat_rs   <= 1'b0;
      lat_rw   <= 1'b1;
      lat_d    <= '0;
      ptr_q    <= '0;
    end else begin
      en_q <= en;
      if (en) begin
        lat_cs_n <= cs_n;
        lat_rs   <= rs;
        lat_rw   <= rw;
        lat_d    <= din;
      end
      if (ptr_load) ptr_q <= lat_d[PTR_W-1:0];
    end
  end

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_load |=> $stable(ptr_q));
  // R2
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_fall |=> !strobe_fall);
  // R9
  deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_cs_n |-> !cfg_wr);
endmodule

// File: rtl/crtc_cfg_bank.sv
module crtc_cfg_bank
  import crtc_regif_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [PTR_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q
);
  logic [NUM_CFG-1:0][DATA_W-1:0] mask_vec;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_mask
    assign mask_vec[g] = field_mask(g);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (wr_en && wr_idx == PTR_W'(i)) cfg_q[i] <= wr_data & mask_vec[i];
      end
    end
  end

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
  // R7
  high_index_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) >= NUM_CFG) |=> $stable(cfg_q));
endmodule

// File: rtl/crtc_pen_latch.sv
module crtc_pen_latch #(
  parameter int MA_W        = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [MA_W-1:0] scan_addr,
  output logic [MA_W-1:0] pen_q
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pen_rise;

  assign pen_rise = sync_q[TOP] & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pen_q  <= '0;
    end else begin
      sync_q <= {sync_q[TOP-1:0], strobe};
      prev_q <= sync_q[TOP];
      if (pen_rise) pen_q <= scan_addr;
    end
  end

  // R11
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pen_rise |=> !pen_rise);
  // R10
  pen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pen_rise |=> $stable(pen_q));
  // R10
  pen_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pen_rise |=> pen_q == $past(scan_addr));
endmodule

// File: rtl/crtc_host_regs.sv
module crtc_host_regs
  import crtc_regif_pkg::*;
#(
  parameter int PTR_W       = 5,
  parameter int MA_W        = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic              bus_en,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic              pen_strobe,
  input  logic [MA_W-1:0]   scan_addr,
  output logic [7:0]        h_total,
  output logic [7:0]        h_disp,
  output logic [7:0]        hs_pos,
  output logic [7:0]        hs_width,
  output logic [6:0]        v_total,
  output logic [4:0]        v_adjust,
  output logic [6:0]        v_disp,
  output logic [6:0]        vs_pos,
  output logic [1:0]        scan_mode,
  output logic [4:0]        row_max,
  output logic [6:0]        cur_start,
  output logic [4:0]        cur_end,
  output logic [MA_W-1:0]   start_addr,
  output logic [MA_W-1:0]   cursor_addr
);
  localparam int HI_W = MA_W - DATA_W;

  logic                           cfg_wr, rd_sel;
  logic [DATA_W-1:0]              wr_data, rd_word;
  logic [PTR_W-1:0]               ptr_q;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg;
  logic [MA_W-1:0]                pen_q;
  logic [15:0]                    pen_ext;

  crtc_bus_port #(.PTR_W(PTR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .rs(bus_rs), .rw(bus_rw),
    .en(bus_en), .din(bus_din), .cfg_wr(cfg_wr), .wr_data(wr_data),
    .ptr_q(ptr_q), .rd_sel(rd_sel)
  );

  crtc_cfg_bank #(.PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_idx(ptr_q),
    .wr_data(wr_data), .cfg_q(cfg)
  );

  crtc_pen_latch #(.MA_W(MA_W), .SYNC_STAGES(SYNC_STAGES)) u_pen (
    .clk(clk), .rst_n(rst_n), .strobe(pen_strobe), .scan_addr(scan_addr),
    .pen_q(pen_q)
  );

  assign pen_ext = 16'(pen_q);

  always_comb begin
    rd_word = '0;
    if (bus_rs) begin
      case (ptr_q)
        PTR_W'(IDX_CUR_HI): rd_word = cfg[IDX_CUR_HI];
        PTR_W'(IDX_CUR_LO): rd_word = cfg[IDX_CUR_LO];
        PTR_W'(IDX_PEN_HI): rd_word = pen_ext[15:8];
        PTR_W'(IDX_PEN_LO): rd_word = pen_ext[7:0];
        default:            rd_word = '0;
      endcase
    end
  end

  assign bus_oe   = rd_sel;
  assign bus_dout = rd_sel ? rd_word : '0;

  assign h_total     = cfg[0];
  assign h_disp      = cfg[1];
  assign hs_pos      = cfg[2];
  assign hs_width    = cfg[3];
  assign v_total     = cfg[4][6:0];
  assign v_adjust    = cfg[5][4:0];
  assign v_disp      = cfg[6][6:0];
  assign vs_pos      = cfg[7][6:0];
  assign scan_mode   = cfg[8][1:0];
  assign row_max     = cfg[9][4:0];
  assign cur_start   = cfg[10][6:0];
  assign cur_end     = cfg[11][4:0];
  assign start_addr  = {cfg[12][HI_W-1:0], cfg[13]};
  assign cursor_addr = {cfg[14][HI_W-1:0], cfg[15]};

  logic unused_bits;
  assign unused_bits = ^{cfg[4][7], cfg[5][7:5], cfg[6][7], cfg[7][7],
                         cfg[8][7:2], cfg[9][7:5], cfg[10][7], cfg[11][7:5],
                         cfg[12][7:HI_W]};

  // R5
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && (!bus_rs || ptr_q < PTR_W'(IDX_CUR_HI))) |-> bus_dout == '0);
  // R6
  cursor_hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && bus_rs && ptr_q == PTR_W'(IDX_CUR_HI)) |-> bus_dout[7:6] == 2'b00);
  // R10
  pen_hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && bus_rs && ptr_q == PTR_W'(IDX_PEN_HI)) |-> bus_dout[7:6] == 2'b00);
endmodule

// File: tb/tb_crtc_host_regs.sv
`timescale 1ns/1ps
module tb_crtc_host_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs_n = 1'b1, bus_rs = 1'b0, bus_rw = 1'b1, bus_en = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic bus_oe;
  logic pen_strobe = 1'b0;
  logic [13:0] scan_addr = 14'd0;
  logic [7:0] h_total, h_disp, hs_pos, hs_width;
  logic [6:0] v_total, v_disp, vs_pos, cur_start;
  logic [4:0] v_adjust, row_max, cur_end;
  logic [1:0] scan_mode;
  logic [13:0] start_addr, cursor_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  int model_cfg [16];
  int model_ptr = 0;
  int model_pen = 0;

  always #4 clk = ~clk;

  crtc_host_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rs(bus_rs),
    .bus_rw(bus_rw), .bus_en(bus_en), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .pen_strobe(pen_strobe), .scan_addr(scan_addr),
    .h_total(h_total), .h_disp(h_disp), .hs_pos(hs_pos), .hs_width(hs_width),
    .v_total(v_total), .v_adjust(v_adjust), .v_disp(v_disp), .vs_pos(vs_pos),
    .scan_mode(scan_mode), .row_max(row_max), .cur_start(cur_start),
    .cur_end(cur_end), .start_addr(start_addr), .cursor_addr(cursor_addr)
  );

  // kept width per index, as listed in R4
  function automatic int kept_bits(input int idx);
    if (idx == 8) return 2;
    if (idx == 5 || idx == 9 || idx == 11) return 5;
    if (idx == 12 || idx == 14) return 6;
    if (idx == 4 || idx == 6 || idx == 7 || idx == 10) return 7;
    return 8;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_read();
    if (!bus_rs) return 0;
    case (model_ptr)
      14: return model_cfg[14];
      15: return model_cfg[15];
      16: return (model_pen >> 8) & 8'h3F;
      17: return model_pen & 8'hFF;
      default: return 0;
    endcase
  endfunction

  // reference compared on every clock, midway through the low phase
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      chk("R3 h_total", int'(h_total), model_cfg[0]);
      chk("R3 h_disp", int'(h_disp), model_cfg[1]);
      chk("R3 hs_pos", int'(hs_pos), model_cfg[2]);
      chk("R3 hs_width", int'(hs_width), model_cfg[3]);
      chk("R3 v_total", int'(v_total), model_cfg[4]);
      chk("R3 v_adjust", int'(v_adjust), model_cfg[5]);
      chk("R3 v_disp", int'(v_disp), model_cfg[6]);
      chk("R3 vs_pos", int'(vs_pos), model_cfg[7]);
      chk("R3 scan_mode", int'(scan_mode), model_cfg[8]);
      chk("R3 row_max", int'(row_max), model_cfg[9]);
      chk("R3 cur_start", int'(cur_start), model_cfg[10]);
      chk("R3 cur_end", int'(cur_end), model_cfg[11]);
      chk("R3 start_addr", int'(start_addr), model_cfg[12] * 256 + model_cfg[13]);
      chk("R3 cursor_addr", int'(cursor_addr), model_cfg[14] * 256 + model_cfg[15]);
      chk("R8 bus_oe", int'(bus_oe), int'(!bus_cs_n && bus_rw && bus_en));
      if (bus_oe) chk("R5/R6/R10 read data", int'(bus_dout), exp_read());
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      scan_addr = scan_addr + 14'd37;
    end
  end

  task automatic bus_write(input bit csn, input bit rs, input int data);
    @(negedge clk);
    bus_cs_n = csn; bus_rs = rs; bus_rw = 1'b0; bus_din = 8'(data); bus_en = 1'b1;
    @(negedge clk);
    bus_en = 1'b0;
    @(posedge clk);
    if (!csn) begin
      if (!rs) model_ptr = data & 31;
      else if (model_ptr < 16)
        model_cfg[model_ptr] = data & ((1 << kept_bits(model_ptr)) - 1);
    end
    @(negedge clk);
    bus_cs_n = 1'b1; bus_rw = 1'b1;
  endtask

  task automatic set_reg(input int idx, input int data);
    bus_write(1'b0, 1'b0, idx);
    bus_write(1'b0, 1'b1, data);
  endtask

  task automatic bus_read(input string req, input bit rs, input int exp);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_rs = rs; bus_rw = 1'b1; bus_en = 1'b1;
    #2;
    chk(req, int'(bus_oe), 1);
    chk(req, int'(bus_dout), exp);
    @(negedge clk);
    bus_en = 1'b0; bus_cs_n = 1'b1;
  endtask

  task automatic pen_pulse(input int hold);
    @(negedge clk);
    pen_strobe = 1'b1;
    repeat (3) @(posedge clk);
    model_pen = int'(scan_addr);
    repeat (hold) @(negedge clk);
    @(negedge clk);
    pen_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model_cfg[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 h_total", int'(h_total), 0);
    chk("R1 start_addr", int'(start_addr), 0);
    chk("R1 cursor_addr", int'(cursor_addr), 0);
    chk("R1 bus_oe", int'(bus_oe), 0);
    set_reg(17, 0);                      // index write, data ignored
    bus_read("R1 pen low after reset", 1'b1, 0);

    // R2 R3 distinct patterns into every register
    for (int i = 0; i < 16; i++) set_reg(i, (8'hA5 ^ (i * 29)) & 255);
    for (int i = 0; i < 16; i++) set_reg(i, (i * 17 + 3) & 255);
    // R4 all-ones truncation
    for (int i = 0; i < 16; i++) set_reg(i, 255);
    chk("R4 v_adjust width", int'(v_adjust), 31);
    chk("R4 scan_mode width", int'(scan_mode), 3);
    chk("R4 start_addr width", int'(start_addr), 16'h3FFF);

    // R5 write-only and out-of-range reads
    for (int i = 0; i < 14; i++) begin
      bus_write(1'b0, 1'b0, i);
      bus_read("R5 write-only read", 1'b1, 0);
    end
    bus_write(1'b0, 1'b0, 22);
    bus_read("R5 out-of-range read", 1'b1, 0);
    bus_read("R5 index location read", 1'b0, 0);

    // R6 cursor readback
    set_reg(14, 8'hE9);
    set_reg(15, 8'h3C);
    bus_write(1'b0, 1'b0, 14);
    bus_read("R6 cursor high", 1'b1, 8'h29);
    bus_write(1'b0, 1'b0, 15);
    bus_read("R6 cursor low", 1'b1, 8'h3C);

    // R7 writes to read-only and unused indices
    set_reg(16, 8'h55);
    set_reg(17, 8'hAA);
    set_reg(18, 8'h12);
    set_reg(31, 8'h77);
    chk("R7 h_total kept", int'(h_total), 255);
    bus_write(1'b0, 1'b0, 16);
    bus_read("R7 pen high untouched", 1'b1, 0);

    // R9 deselected transfers
    bus_write(1'b0, 1'b0, 1);
    bus_write(1'b1, 1'b1, 8'h11);
    bus_write(1'b1, 1'b0, 15);
    chk("R9 h_disp unchanged", int'(h_disp), 255);
    set_reg(1, 8'h42);
    chk("R9 index still 1", int'(h_disp), 8'h42);

    // R8 read-type strobes while deselected or writing
    @(negedge clk);
    bus_cs_n = 1'b1; bus_rw = 1'b1; bus_en = 1'b1;
    #2 chk("R8 deselected read", int'(bus_oe), 0);
    @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
    bus_cs_n = 1'b0; bus_rw = 1'b1; bus_en = 1'b0;
    #2 chk("R8 enable low", int'(bus_oe), 0);
    @(negedge clk);
    bus_cs_n = 1'b1;

    // R10 light-pen capture
    pen_pulse(0);
    bus_write(1'b0, 1'b0, 16);
    bus_read("R10 pen high", 1'b1, (model_pen >> 8) & 63);
    bus_write(1'b0, 1'b0, 17);
    bus_read("R10 pen low", 1'b1, model_pen & 255);
    // R11 long hold captures once
    pen_pulse(12);
    bus_read("R11 pen low after long hold", 1'b1, model_pen & 255);
    bus_write(1'b0, 1'b0, 16);
    bus_read("R11 pen high after long hold", 1'b1, (model_pen >> 8) & 63);
    pen_pulse(3);
    bus_read("R10 pen high second capture", 1'b1, (model_pen >> 8) & 63);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule